// File: doc/BRIEF.md
# Stack Push/Pop Bus Sequencer

This block runs the bus side of a 16-bit register transfer to or from a byte-wide stack in memory. A one-clock start pulse begins an operation and selects its direction. The block then runs four machine cycles of three T-states each. The first two machine cycles read the two instruction bytes at the instruction address and the next one. The last two machine cycles move the register's two bytes to or from the stack, with the stack pointer stepped by one in each.

A push moves the pointer down before each write and stores the high byte first. A pop reads the low byte at the pointer, steps up, and then reads the high byte. The block drives the memory request, read and write strobes, the address and the write byte. It captures read data at the close of each data cycle and pulses a done flag when the operation ends. The stack pointer lives inside the block and comes out of reset at a parameter value. Instruction decode and the memory itself sit outside.

Top module: `stk_xfer_seq`

## Requirements
- R1: While reset is held and until the first start, `sp` equals the reset value SP_RST (default 0x0001), `pop_val` is 0, and `mreq`, `rd`, `wr`, `done`, `addr` and `wdata` are all 0.
- R2: A start accepted at a clock edge is followed by exactly 12 busy clocks (machine cycles 1 to 4, each T1, T2, T3), and `done` is high for exactly the one clock after the last T3.
- R3: In machine cycle 1 `addr` equals the `pc_in` value latched at start, and in machine cycle 2 it equals that value plus 1. Both are reads (`mreq` and `rd` high in T2/T3) with `wr` low.
- R4: In every machine cycle `mreq` and `rd` or `wr` are low in T1 and high in T2 and T3, never `rd` and `wr` together, and `addr` holds one value through all three T-states.
- R5: A push with pointer S writes the high byte of the `push_val` latched at start to address S-1 in machine cycle 3, and the low byte to S-2 in machine cycle 4. `wdata` holds the byte through T1 to T3, and `sp` drops by one at the end of each of those machine cycles.
- R6: A pop with pointer S reads address S in machine cycle 3 into `pop_val[7:0]` and address S+1 in machine cycle 4 into `pop_val[15:8]`. Each byte is taken from `rdata` at the end of T3, and `sp` rises by one at the end of each of those machine cycles.
- R7: When `done` is high, `sp` equals its value before the operation plus 2 (pop) or minus 2 (push), modulo 2^16, including across 0x0000/0xFFFF.
- R8: A start while the block is busy is ignored: the running operation keeps its timing, its direction and its data. A start in the clock where `done` is high is accepted.
- R9: When no operation is running, `mreq`, `rd` and `wr` are low and `addr` and `wdata` are 0. `wdata` is also 0 in fetch and pop machine cycles.
- R10: `pop_val` changes only at the end of T3 of a pop data cycle. A push leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-clock request to begin an operation |
| op_push | input | 1 | Direction at start: 1 push, 0 pop |
| pc_in | input | 16 | Instruction address for the two fetch cycles |
| push_val | input | 16 | Register value to push, latched at start |
| rdata | input | 8 | Memory read byte |
| addr | output | 16 | Memory address |
| wdata | output | 8 | Memory write byte |
| mreq | output | 1 | Memory request strobe |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| pop_val | output | 16 | Last popped register value |
| sp | output | 16 | Stack pointer |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest situation to reach is a start arriving while an operation is already running, and in particular in the very clock that carries `done`, where it must be accepted with no idle clock. The stimulus holds `start` high across two complete operations, so that start is seen in every busy state and again in the done clock, and it also pulses start once in the middle of a pop. Pointer wraparound is reached by pushing from the reset value 0x0001 and then popping back across 0xFFFF to 0x0000.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;
  // machine cycles per operation and how many of them fetch opcode bytes
  localparam int MC_N    = 4;
  localparam int FETCH_N = 2;
  localparam int MCW     = $clog2(MC_N);

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2
  } tphase_e;
endpackage

// File: rtl/stk_tseq.sv
`timescale 1ns/1ps
// T-state / machine-cycle counter with start acceptance and done pulse
module stk_tseq
  import stk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic [MCW-1:0] mc,
  output tphase_e        ts,
  output logic           accept,
  output logic           t3_end,
  output logic           done
);
  logic           busy_q, busy_d;
  logic [MCW-1:0] mc_q, mc_d;
  tphase_e        ts_q, ts_d;
  logic           done_q, done_d;
  logic           last_mc;

  always_comb begin
    busy_d  = busy_q;
    mc_d    = mc_q;
    ts_d    = ts_q;
    accept  = start & ~busy_q;
    t3_end  = busy_q & (ts_q == PH_T3);
    last_mc = (mc_q == MCW'(MC_N - 1));
    done_d  = t3_end & last_mc;
    if (accept) begin
      busy_d = 1'b1;
      mc_d   = '0;
      ts_d   = PH_T1;
    end else if (busy_q) begin
      case (ts_q)
        PH_T1:   ts_d = PH_T2;
        PH_T2:   ts_d = PH_T3;
        default: begin
          ts_d = PH_T1;
          if (last_mc) busy_d = 1'b0;
          else         mc_d   = mc_q + MCW'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mc_q   <= '0;
      ts_q   <= PH_T1;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      mc_q   <= mc_d;
      ts_q   <= ts_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign mc   = mc_q;
  assign ts   = ts_q;
  assign done = done_q;
endmodule

// File: rtl/stk_sp_unit.sv
`timescale 1ns/1ps
// Stack pointer register and the data-cycle address it implies
module stk_sp_unit #(
  parameter int            AW     = 16,
  parameter logic [AW-1:0] SP_RST = {{(AW-1){1'b0}}, 1'b1}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          dir_dn,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] data_addr
);
  logic [AW-1:0] sp_q, sp_d, sp_dec;

  always_comb begin
    sp_dec    = sp_q - AW'(1);
    data_addr = dir_dn ? sp_dec : sp_q;
    sp_d      = sp_q;
    if (step_en) sp_d = dir_dn ? sp_dec : sp_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= SP_RST;
    else        sp_q <= sp_d;
  end

  assign sp = sp_q;
endmodule

// File: rtl/stk_dpath.sv
`timescale 1ns/1ps
// Push operand hold register, byte select and pop capture
module stk_dpath #(
  parameter int DW = 8,
  localparam int RW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] val_in,
  input  logic          cap_en,
  input  logic          sel_hi,
  input  logic [DW-1:0] rdata,
  output logic [DW-1:0] wbyte,
  output logic [RW-1:0] pop_val
);
  logic [RW-1:0] push_q, push_d;
  logic [RW-1:0] pop_q, pop_d;

  always_comb begin
    push_d = load ? val_in : push_q;
    pop_d  = pop_q;
    if (cap_en) begin
      if (sel_hi) pop_d[RW-1:DW] = rdata;
      else        pop_d[DW-1:0]  = rdata;
    end
    wbyte = sel_hi ? push_q[RW-1:DW] : push_q[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q <= '0;
      pop_q  <= '0;
    end else begin
      push_q <= push_d;
      pop_q  <= pop_d;
    end
  end

  assign pop_val = pop_q;
endmodule

// File: rtl/stk_xfer_seq.sv
`timescale 1ns/1ps
// Top: sequences fetch and stack data machine cycles for a register push/pop
module stk_xfer_seq
  import stk_pkg::*;
#(
  parameter int            AW     = 16,
  parameter int            DW     = 8,
  parameter logic [AW-1:0] SP_RST = {{(AW-1){1'b0}}, 1'b1}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_push,
  input  logic [AW-1:0]   pc_in,
  input  logic [2*DW-1:0] push_val,
  input  logic [DW-1:0]   rdata,
  output logic [AW-1:0]   addr,
  output logic [DW-1:0]   wdata,
  output logic            mreq,
  output logic            rd,
  output logic            wr,
  output logic [2*DW-1:0] pop_val,
  output logic [AW-1:0]   sp,
  output logic            done
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  logic           busy_w, accept_w, t3_end_w, done_w;
  logic [MCW-1:0] mc_w;
  tphase_e        ts_w;

  stk_tseq u_tseq (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .start  (start),
    .busy   (busy_w),
    .mc     (mc_w),
    .ts     (ts_w),
    .accept (accept_w),
    .t3_end (t3_end_w),
    .done   (done_w)
  );

  // operation context latched at acceptance
  logic          op_q, op_d;
  logic [AW-1:0] pc_q, pc_d;

  always_comb begin
    op_d = accept_w ? op_push : op_q;
    pc_d = accept_w ? pc_in   : pc_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      op_q <= 1'b0;
      pc_q <= '0;
    end else begin
      op_q <= op_d;
      pc_q <= pc_d;
    end
  end

  logic          is_fetch, data_cyc, step_en, sel_hi, cap_en;
  logic [AW-1:0] data_addr;
  logic [DW-1:0] wbyte;

  always_comb begin
    is_fetch = (mc_w < MCW'(FETCH_N));
    data_cyc = busy_w & ~is_fetch;
    step_en  = t3_end_w & ~is_fetch;
    // push sends the high byte first; pop fills the low byte first
    sel_hi   = op_q ? (mc_w == MCW'(FETCH_N)) : (mc_w == MCW'(FETCH_N + 1));
    cap_en   = step_en & ~op_q;
  end

  stk_sp_unit #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .step_en   (step_en),
    .dir_dn    (op_q),
    .sp        (sp),
    .data_addr (data_addr)
  );

  stk_dpath #(.DW(DW)) u_dp (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load    (accept_w),
    .val_in  (push_val),
    .cap_en  (cap_en),
    .sel_hi  (sel_hi),
    .rdata   (rdata),
    .wbyte   (wbyte),
    .pop_val (pop_val)
  );

  always_comb begin
    if (!busy_w)      addr = '0;
    else if (is_fetch) addr = pc_q + AW'(mc_w);
    else              addr = data_addr;
    mreq  = busy_w & (ts_w != PH_T1);
    rd    = mreq & (is_fetch | ~op_q);
    wr    = mreq & ~is_fetch & op_q;
    wdata = (data_cyc & op_q) ? wbyte : '0;
  end

  assign done = done_w;
endmodule

// File: rtl/stk_xfer_seq_chk.sv
`timescale 1ns/1ps
// Property checker for stk_xfer_seq, attached by bind below
module stk_xfer_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [1:0]      mc,
  input logic [1:0]      ts,
  input logic            op_q,
  input logic            mreq,
  input logic            rd,
  input logic            wr,
  input logic [AW-1:0]   addr,
  input logic [AW-1:0]   sp,
  input logic [2*DW-1:0] pop_val,
  input logic            done
);
  logic in_t3, data_t3, last_t3;
  assign in_t3   = busy && (ts == 2'd2);
  assign data_t3 = in_t3 && (mc >= 2'd2);
  assign last_t3 = in_t3 && (mc == 2'd3);

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mreq |-> (rd != wr));

  assert_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ts != 2'd0) |-> (addr == $past(addr)));

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mreq && !rd && !wr));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_t3 |=> (done && !busy));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_t3) |=> busy);

  assert_push_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_t3 && op_q) |=> (sp == $past(sp) - AW'(1)));

  assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_t3 && !op_q) |=> (sp == $past(sp) + AW'(1)));

  assert_pop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_t3 && !op_q) |=> $stable(pop_val));
endmodule

bind stk_xfer_seq stk_xfer_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy_w),
  .mc      (mc_w),
  .ts      (ts_w),
  .op_q    (op_q),
  .mreq    (mreq),
  .rd      (rd),
  .wr      (wr),
  .addr    (addr),
  .sp      (sp),
  .pop_val (pop_val),
  .done    (done)
);

// File: tb/tb_stk_xfer_seq.sv
`timescale 1ns/1ps
module tb_stk_xfer_seq;
  localparam logic [15:0] SP0 = 16'h0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_push = 1'b0;
  logic [15:0] pc_in = 16'h0000;
  logic [15:0] push_val = 16'h0000;
  logic [7:0]  rdata = 8'h00;
  logic [15:0] addr, sp, pop_val;
  logic [7:0]  wdata;
  logic        mreq, rd, wr, done;

  always #2 clk = ~clk;

  stk_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_push(op_push),
    .pc_in(pc_in), .push_val(push_val), .rdata(rdata),
    .addr(addr), .wdata(wdata), .mreq(mreq), .rd(rd), .wr(wr),
    .pop_val(pop_val), .sp(sp), .done(done)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit r1_win = 1'b1;
  bit r8_win = 1'b0;

  // byte memory; unwritten locations return a pattern derived from the address
  logic [7:0] mem [int];
  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // behavioural reference: k = clock index inside an operation (0 = idle)
  int          k = 0;
  logic [15:0] m_sp = SP0, m_pv = 16'h0000, m_pc = 16'h0000, m_val = 16'h0000;
  logic        m_push = 1'b0, m_done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; m_sp = SP0; m_pv = 16'h0000; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (k > 0) begin
        if (((k - 1) % 3) == 2 && ((k - 1) / 3) >= 2) begin
          if (m_push) m_sp = m_sp - 16'd1;
          else begin
            if ((k - 1) / 3 == 2) m_pv[7:0] = rdata;
            else                  m_pv[15:8] = rdata;
            m_sp = m_sp + 16'd1;
          end
        end
        if (k == 12) begin k = 0; m_done = 1'b1; end
        else k = k + 1;
      end else if (start) begin
        k = 1; m_pc = pc_in; m_push = op_push; m_val = push_val;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // compare every output in the middle of each clock, then serve memory
  always @(negedge clk) begin
    int mc, ts;
    bit busy, fetch;
    logic [15:0] e_addr;
    logic [7:0]  e_wd;
    logic e_mreq, e_rd, e_wr;
    string t_a, t_s, t_w, t_d, t_sp, t_pv;
    if (!finished) begin
      busy  = (k > 0);
      mc    = busy ? (k - 1) / 3 : 0;
      ts    = busy ? (k - 1) % 3 : 0;
      fetch = busy && (mc < 2);
      if (!busy)      e_addr = 16'h0000;
      else if (fetch) e_addr = m_pc + 16'(mc);
      else            e_addr = m_push ? m_sp - 16'd1 : m_sp;
      e_mreq = busy && ts != 0;
      e_rd   = e_mreq && (fetch || !m_push);
      e_wr   = e_mreq && !fetch && m_push;
      e_wd   = (busy && !fetch && m_push) ? ((mc == 2) ? m_val[15:8] : m_val[7:0]) : 8'h00;
      t_a  = !busy ? "R9" : fetch ? "R3" : m_push ? "R5" : "R6";
      t_s  = busy ? "R4" : "R9";
      t_w  = busy ? "R5" : "R9";
      t_d  = "R2";
      t_sp = m_done ? "R7" : "R5/6";
      t_pv = (busy && !fetch && !m_push) ? "R6" : "R10";
      if (!rst_n || r1_win) begin
        t_a = "R1"; t_s = "R1"; t_w = "R1"; t_d = "R1"; t_sp = "R1"; t_pv = "R1";
      end else if (r8_win) begin
        t_a = "R8"; t_s = "R8"; t_d = "R8"; t_sp = "R8";
      end
      chk(t_a,  "addr",    32'(addr),    32'(e_addr));
      chk(t_w,  "wdata",   32'(wdata),   32'(e_wd));
      chk(t_s,  "mreq",    32'(mreq),    32'(e_mreq));
      chk(t_s,  "rd",      32'(rd),      32'(e_rd));
      chk(t_s,  "wr",      32'(wr),      32'(e_wr));
      chk(t_d,  "done",    32'(done),    32'(m_done));
      chk(t_sp, "sp",      32'(sp),      32'(m_sp));
      chk(t_pv, "pop_val", 32'(pop_val), 32'(m_pv));
      if (wr) mem[int'(addr)] = wdata;
      rdata = rd ? mem_rd(addr) : 8'h00;
    end
  end

  task automatic run_op(input logic p, input logic [15:0] v, input logic [15:0] pcv);
    @(negedge clk);
    start = 1'b1; op_push = p; push_val = v; pc_in = pcv;
    @(negedge clk);
    // scramble inputs so that only the latched values can be correct
    start = 1'b0; op_push = ~p; push_val = ~v; pc_in = ~pcv;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    r1_win = 1'b0;
    run_op(1'b1, 16'hA1B2, 16'h0100);  // R5, R7: pointer wraps 0001 -> FFFF
    run_op(1'b0, 16'h0000, 16'h0200);  // R6, R7: back across FFFF/0000
    run_op(1'b1, 16'h1234, 16'h0300);
    run_op(1'b1, 16'h5678, 16'hFFFF);  // R3: fetch address wraps
    run_op(1'b0, 16'h0000, 16'h0310);
    run_op(1'b0, 16'h0000, 16'h0320);  // R10: pop_val holds across pushes
    // R8: start held through two whole operations, accepted again at done
    @(negedge clk);
    r8_win = 1'b1;
    start = 1'b1; op_push = 1'b1; push_val = 16'hBEEF; pc_in = 16'h0400;
    repeat (26) @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    // R8: a pop with a push request pulsed in its middle
    start = 1'b1; op_push = 1'b0; pc_in = 16'h0500;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; op_push = 1'b1; push_val = 16'h0F0F;
    @(negedge clk);
    start = 1'b0; op_push = 1'b0;
    repeat (10) @(negedge clk);
    r8_win = 1'b0;
    run_op(1'b0, 16'h0000, 16'h0600);
    run_op(1'b0, 16'h0000, 16'h0610);  // R6: reads never-written memory
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule